// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This peripheral guards a processor against hangs with a down-counter that software must service. It is set up through a small register bus. The bus has a word address, a write strobe, write data and combinational read data. Once started, the counter loses one per clock. When it first reaches zero, it flags a timeout interrupt and reloads. If it reaches zero again before software has cleared that interrupt, and reset escalation is enabled, it issues a one-cycle system reset request. The same pulse returns the block to its power-up state.

Software can guard the control and load registers with a key-based write lock. The timeout can be routed to either a standard or a non-maskable interrupt line. A test bit lets a debug halt freeze the count, so a stopped processor is not reset during debugging.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset these registers read zero: control (word 0), raw status (word 3), masked status (word 4), lock (word 6) and test (word 7). Load (word 1) and count (word 2) read all ones. The interrupt and reset outputs are low.
- R2: Writing control bit0 as 1 starts the counter, which then falls by one on each clock edge. Once set, bit0 stays 1 against any write and is cleared only by a block reset.
- R3: When the running counter is at zero and no timeout is pending, the next edge sets the pending flag (raw status bit0) and reloads the counter from the load register.
- R4: When the running counter is at zero, the timeout is still pending and control bit1 (reset enable) is 1, the next edge raises the system reset request for exactly one cycle. The edge after that returns every register to its R1 value. With bit1 at 0 there is no request; the counter reloads and the flag stays set.
- R5: An accepted write to the load register also copies the written value into the counter on the same edge.
- R6: An accepted write of zero to the load register sets the pending flag on that edge.
- R7: Writing word 6 with any value other than 32'h1ACCE551 engages the lock, and word 6 then reads 32'h00000001. Writing 32'h1ACCE551 releases the lock, and word 6 then reads 0. While locked, writes to control and load have no effect.
- R8: Masked status (word 4, bit0) equals raw status bit0 AND control bit0.
- R9: Writing word 5 with bit0 set clears the pending flag.
- R10: Control bit2 selects the timeout line. With bit2 at 0, the standard interrupt output carries the masked status and the non-maskable output is low. With bit2 at 1, the roles swap.
- R11: With test bit0 set and the debug-halt input high, the counter holds its value. With test bit0 clear, it keeps counting whatever the debug-halt input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Word address of the register accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dbg_halt | input | 1 | High while the processor is halted by a debugger |
| irq_std | output | 1 | Standard timeout interrupt |
| irq_nmi | output | 1 | Non-maskable timeout interrupt |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
On every cycle, the assertions check the following:
- the reset request lasts one cycle, follows a pending timeout with escalation enabled, and leaves the block cleared;
- the run bit stays set once set;
- a locked control write changes nothing;
- a stalled and halted counter stays frozen;
- the two interrupt lines are never high together, and neither is high unless the counter runs with a timeout pending.

Only the bench scenarios can show the exact timing. These cover the cycle on which the first and second expiries land, the immediate copy and the zero-load interrupt, the key values and lock read codes, and the clear register's effect on raw and masked status.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL   = 3'd0,
    REG_LOAD   = 3'd1,
    REG_COUNT  = 3'd2,
    REG_RAW    = 3'd3,
    REG_MASKED = 3'd4,
    REG_CLEAR  = 3'd5,
    REG_LOCK   = 3'd6,
    REG_TEST   = 3'd7
  } reg_sel_e;

  localparam logic [31:0] UNLOCK_KEY  = 32'h1ACC_E551;
  localparam logic [31:0] LOCKED_CODE = 32'h0000_0001;
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_clr,
  input  logic       wr_ctrl,
  input  logic       wr_lock,
  input  logic       wr_test,
  input  logic [2:0] ctrl_bits,
  input  logic       test_bit,
  input  logic       key_hit,
  output logic       run,
  output logic       rst_en,
  output logic       nmi_sel,
  output logic       locked,
  output logic       stall_en
);
  logic run_d, rst_en_d, nmi_d, lock_d, stall_d;

  always_comb begin
    run_d    = run;
    rst_en_d = rst_en;
    nmi_d    = nmi_sel;
    lock_d   = locked;
    stall_d  = stall_en;
    if (wr_ctrl && !locked) begin
      run_d    = run | ctrl_bits[0];
      rst_en_d = ctrl_bits[1];
      nmi_d    = ctrl_bits[2];
    end
    if (wr_lock) lock_d = !key_hit;
    if (wr_test) stall_d = test_bit;
    if (soft_clr) begin
      run_d    = 1'b0;
      rst_en_d = 1'b0;
      nmi_d    = 1'b0;
      lock_d   = 1'b0;
      stall_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      rst_en   <= 1'b0;
      nmi_sel  <= 1'b0;
      locked   <= 1'b0;
      stall_en <= 1'b0;
    end else begin
      run      <= run_d;
      rst_en   <= rst_en_d;
      nmi_sel  <= nmi_d;
      locked   <= lock_d;
      stall_en <= stall_d;
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          rst_en,
  input  logic          stall_en,
  input  logic          dbg_halt,
  input  logic          load_wr,
  input  logic          clr_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] count,
  output logic [DW-1:0] load_val,
  output logic          pending,
  output logic          fire
);
  localparam logic [DW-1:0] ALL_ONES = '1;

  logic [DW-1:0] cnt_d, load_d;
  logic          pend_d, fire_d, tick;

  assign tick = run && !(stall_en && dbg_halt);

  always_comb begin
    cnt_d  = count;
    load_d = load_val;
    pend_d = pending;
    fire_d = 1'b0;
    if (clr_wr) pend_d = 1'b0;
    if (tick) begin
      if (count == '0) begin
        cnt_d = load_val;
        if (pending) fire_d = rst_en;
        else         pend_d = 1'b1;
      end else begin
        cnt_d = count - 1'b1;
      end
    end
    if (load_wr) begin
      load_d = wdata;
      cnt_d  = wdata;
      if (wdata == '0) pend_d = 1'b1;
    end
    if (fire) begin
      cnt_d  = ALL_ONES;
      load_d = ALL_ONES;
      pend_d = 1'b0;
      fire_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= ALL_ONES;
      load_val <= ALL_ONES;
      pending  <= 1'b0;
      fire     <= 1'b0;
    end else begin
      count    <= cnt_d;
      load_val <= load_d;
      pending  <= pend_d;
      fire     <= fire_d;
    end
  end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              dbg_halt,
  output logic              irq_std,
  output logic              irq_nmi,
  output logic              sys_rst_req
);
  logic [1:0]    rst_sync;
  logic          rst_core_n;
  logic          run, rst_en, nmi_sel, locked, stall_en;
  logic          pending, fire, masked;
  logic [DW-1:0] count_val, load_val;
  logic          wr_ctrl, wr_load, wr_clear, wr_lock, wr_test, key_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign wr_ctrl  = bus_we && (bus_addr == REG_CTRL);
  assign wr_load  = bus_we && (bus_addr == REG_LOAD) && !locked;
  assign wr_clear = bus_we && (bus_addr == REG_CLEAR) && bus_wdata[0];
  assign wr_lock  = bus_we && (bus_addr == REG_LOCK);
  assign wr_test  = bus_we && (bus_addr == REG_TEST);
  assign key_hit  = (bus_wdata == DW'(UNLOCK_KEY));

  wdog_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .soft_clr  (fire),
    .wr_ctrl   (wr_ctrl),
    .wr_lock   (wr_lock),
    .wr_test   (wr_test),
    .ctrl_bits (bus_wdata[2:0]),
    .test_bit  (bus_wdata[0]),
    .key_hit   (key_hit),
    .run       (run),
    .rst_en    (rst_en),
    .nmi_sel   (nmi_sel),
    .locked    (locked),
    .stall_en  (stall_en)
  );

  wdog_core #(.DW(DW)) u_core (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (run),
    .rst_en   (rst_en),
    .stall_en (stall_en),
    .dbg_halt (dbg_halt),
    .load_wr  (wr_load),
    .clr_wr   (wr_clear),
    .wdata    (bus_wdata),
    .count    (count_val),
    .load_val (load_val),
    .pending  (pending),
    .fire     (fire)
  );

  assign masked      = pending && run;
  assign irq_std     = masked && !nmi_sel;
  assign irq_nmi     = masked && nmi_sel;
  assign sys_rst_req = fire;

  always_comb begin
    bus_rdata = '0;
    case (reg_sel_e'(bus_addr))
      REG_CTRL:   bus_rdata[2:0] = {nmi_sel, rst_en, run};
      REG_LOAD:   bus_rdata = load_val;
      REG_COUNT:  bus_rdata = count_val;
      REG_RAW:    bus_rdata[0] = pending;
      REG_MASKED: bus_rdata[0] = masked;
      REG_LOCK:   bus_rdata = locked ? DW'(LOCKED_CODE) : '0;
      REG_TEST:   bus_rdata[0] = stall_en;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] bus_addr,
  input logic              bus_we,
  input logic              dbg_halt,
  input logic              irq_std,
  input logic              irq_nmi,
  input logic              sys_rst_req,
  input logic              run,
  input logic              rst_en,
  input logic              nmi_sel,
  input logic              locked,
  input logic              stall_en,
  input logic              pending,
  input logic [DW-1:0]     count_val
);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);

  a_r4_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(pending && rst_en));

  a_r4_clears_state: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> (!run && !pending && !locked));

  a_r2_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sys_rst_req) |=> run);

  a_r7_locked_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_we && bus_addr == REG_CTRL && !sys_rst_req)
      |=> $stable({run, rst_en, nmi_sel}));

  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_en && dbg_halt && !(bus_we && bus_addr == REG_LOAD) && !sys_rst_req)
      |=> $stable(count_val));

  a_r10_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_std && irq_nmi));

  a_r8_line_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_std || irq_nmi) |-> (run && pending));
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .dbg_halt    (dbg_halt),
  .irq_std     (irq_std),
  .irq_nmi     (irq_nmi),
  .sys_rst_req (sys_rst_req),
  .run         (run),
  .rst_en      (rst_en),
  .nmi_sel     (nmi_sel),
  .locked      (locked),
  .stall_en    (stall_en),
  .pending     (pending),
  .count_val   (count_val)
);

// File: tb/wdog_two_stage_test.sv
`timescale 1ns/1ps
module wdog_two_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0;
  logic        irq_std, irq_nmi, sys_rst_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit rd_active = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  wdog_two_stage uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
    .irq_std(irq_std), .irq_nmi(irq_nmi), .sys_rst_req(sys_rst_req)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read data queued by the driver
  always @(negedge clk) begin
    if (rd_active && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] e, string tag);
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_active = 1'b1;
    @(posedge clk); #1;
    rd_active = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    dbg_halt = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(1);
    do_reset();
    // R1 reset values
    rd(3'd0, 32'h0, "R1 ctrl");
    rd(3'd1, 32'hFFFF_FFFF, "R1 load");
    rd(3'd2, 32'hFFFF_FFFF, "R1 count");
    rd(3'd3, 32'h0, "R1 raw");
    rd(3'd6, 32'h0, "R1 lock");
    rd(3'd7, 32'h0, "R1 test");
    check("R1 outputs", {29'd0, irq_std, irq_nmi, sys_rst_req}, 32'h0);

    // R5 copy, R2 counting, R3 first expiry, R8, R9
    wr(3'd1, 32'd5);
    rd(3'd2, 32'd5, "R5 count copied");
    wr(3'd0, 32'd1);
    rd(3'd2, 32'd5, "R2 count at start");
    rd(3'd2, 32'd4, "R2 count decrement");
    idle(4);
    rd(3'd3, 32'd1, "R3 raw after expiry");
    rd(3'd4, 32'd1, "R8 masked with run");
    check("R10 std line", {30'd0, irq_std, irq_nmi}, 32'h2);
    wr(3'd0, 32'd0);
    rd(3'd0, 32'd1, "R2 run sticky");
    wr(3'd5, 32'd1);
    rd(3'd3, 32'd0, "R9 cleared");
    rd(3'd3, 32'd1, "R3 second expiry re-flags");

    // R4 escalation to reset
    do_reset();
    wr(3'd1, 32'd3);
    wr(3'd0, 32'd3);
    for (int i = 2; i <= 10; i++) begin
      idle(1);
      check($sformatf("R4 reset pulse edge %0d", i), {31'd0, sys_rst_req}, (i == 9) ? 32'd1 : 32'd0);
    end
    rd(3'd0, 32'd0, "R4 ctrl cleared");
    rd(3'd1, 32'hFFFF_FFFF, "R4 load cleared");

    // R4 no escalation without reset enable
    do_reset();
    wr(3'd1, 32'd3);
    wr(3'd0, 32'd1);
    for (int i = 2; i <= 12; i++) begin
      idle(1);
      check("R4 no pulse when disabled", {31'd0, sys_rst_req}, 32'd0);
    end
    rd(3'd3, 32'd1, "R4 flag kept");

    // R7 lock
    do_reset();
    wr(3'd6, 32'd0);
    rd(3'd6, 32'h1, "R7 locked code");
    wr(3'd1, 32'd7);
    rd(3'd1, 32'hFFFF_FFFF, "R7 load ignored");
    wr(3'd0, 32'd1);
    rd(3'd0, 32'h0, "R7 ctrl ignored");
    wr(3'd6, 32'h1ACC_E551);
    rd(3'd6, 32'h0, "R7 unlocked");
    wr(3'd1, 32'd7);
    rd(3'd1, 32'd7, "R7 load accepted");

    // R6 zero load while stopped
    do_reset();
    wr(3'd1, 32'd0);
    rd(3'd3, 32'd1, "R6 raw on zero load");
    rd(3'd4, 32'd0, "R8 masked without run");
    check("R8 no line when stopped", {30'd0, irq_std, irq_nmi}, 32'h0);

    // R10 non-maskable routing
    do_reset();
    wr(3'd0, 32'd5);
    wr(3'd1, 32'd0);
    check("R10 nmi line", {30'd0, irq_std, irq_nmi}, 32'h1);

    // R11 stall
    do_reset();
    wr(3'd7, 32'd1);
    wr(3'd1, 32'd10);
    dbg_halt = 1'b1;
    wr(3'd0, 32'd1);
    rd(3'd2, 32'd10, "R11 held 1");
    rd(3'd2, 32'd10, "R11 held 2");
    dbg_halt = 1'b0;
    rd(3'd2, 32'd10, "R11 resume");
    rd(3'd2, 32'd9, "R11 counting");
    dbg_halt = 1'b1;
    wr(3'd7, 32'd0);
    rd(3'd2, 32'd8, "R11 stall off halted");
    rd(3'd2, 32'd7, "R11 counts while halted");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule